// File: doc/BRIEF.md
# Serial EEPROM Slave Engine (256 x 8)

This block behaves as a small byte-addressed non-volatile memory on a four-wire SPI bus, in clock modes 0 and 3. All bus pins are brought into a fast system clock domain. Inside that domain the engine does four things:

- It decodes an 8-bit command, then an 8-bit address, then data bytes.
- It streams stored bytes out for reads.
- It gathers write data in a one-page staging buffer.
- When chip select rises after a complete write sequence, it commits the buffer to a register array and starts a self-timed busy period.

An active-low hold input freezes the serial sequence in place. While hold is in effect the output is disabled, and the transfer resumes from the same bit once hold is released.

The engine owns only the write-enable flag and the busy state. The decision whether a write may proceed belongs to a neighbouring protection block. When a write sequence ends, the engine raises a one-cycle request. The request carries the page base address and a flag that says whether the target is memory or the status byte. The neighbour answers in the same cycle with a grant. The neighbour also supplies the upper six bits of the status byte. When a status write is granted, the engine hands it the new status value.

Top module: `spi_mem_top`

## Requirements
- R1: After reset, `spi_so_oe`, `busy`, `prot_req` and `stat_wr` are all 0.
- R2: Command 0x03, then an address byte, returns stored bytes MSB first. Each bit is presented after an SCK falling edge so that it can be sampled on the next rising edge. The address increments after every byte and wraps from 0xFF to 0x00 while CS stays low.
- R3: Command 0x02, then an address byte, then data bytes, stages the data in a page buffer. Bits 7:4 of the address fix the 16-byte page and bits 3:0 wrap within it, so a later byte overwrites an earlier byte at the same slot. The array changes only when CS rises, WEL is set and `prot_grant` is 1.
- R4: A commit drives `busy` high for exactly WRITE_CYCLES clock cycles. Status bit 0 reads 1 during that time. Raising CS while busy has no effect on the busy period.
- R5: While busy, every command other than 0x05 is ignored. In particular, 0x06 does not set WEL and 0x03 never enables SO.
- R6: Command 0x06 sets WEL and 0x04 clears it. The status byte returned by 0x05 is {stat_flags[5:0], WEL, busy}. Every complete write sequence clears WEL at CS rise, whether or not it is granted. Without WEL, no request is raised.
- R7: A write sequence that ends mid-byte, or that carries no data byte, raises no request and starts no busy period.
- R8: Hold takes effect only when `spi_hold_n` falls while SCK is low. While hold is in effect, SO is disabled and SCK and SI are ignored. Releasing hold while SCK is low resumes the transfer at the same bit.
- R9: While CS is high, SO is disabled and any partly received command is discarded.
- R10: Command 0x01, then one byte, raises a request with `prot_status` = 1 at CS rise, provided WEL is set. If granted, `stat_wr` pulses for one cycle carrying the byte on `stat_wdata`, and the busy period starts.
- R11: `prot_req` is a single-cycle pulse in the CS-rise cycle that ends a valid write. For a memory write it carries the page base address on `prot_addr`. A denied request leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause of the serial sequence |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO (0 = high impedance) |
| prot_req | output | 1 | Write permission request pulse |
| prot_addr | output | 8 | Page base of the requested memory write |
| prot_status | output | 1 | Request targets the status byte |
| prot_grant | input | 1 | Same-cycle permission answer |
| stat_flags | input | 6 | Upper status bits held by the protection block |
| stat_wr | output | 1 | Granted status write strobe |
| stat_wdata | output | 8 | New status value |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two functions can meet in one cycle: the status readout and the commit/busy countdown. A status read issued during the busy period must report bit 0 = 1. Its byte is reloaded live at every byte boundary, and the same command sequence is repeated after the countdown, when bit 0 must read 0.

The second overlap is hold against the serial bit counter. Hold is asserted in the middle of a data byte, and SCK and SI are then toggled while held. After release, the completed byte must equal the stored value and the next byte must be the incremented address. This proves that neither the frozen edges nor the release shifted the bit position.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int ADDR_W = 8;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD, PH_RADDR, PH_RDATA, PH_WADDR,
    PH_WDATA, PH_SBYTE, PH_SDONE, PH_STAT
  } phase_t;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic cs_act,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic hold_act
);
  localparam logic [3:0] IDLE_PINS = 4'b1001;

  logic [STAGES-1:0][3:0] pipe_q;
  logic [3:0] pins;
  logic sck_d_q, cs_d_q, hold_q, hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= IDLE_PINS;
    else        pipe_q[0] <= {cs_n, sck, si, hold_n};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= IDLE_PINS;
      else        pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign pins = pipe_q[STAGES-1];

  always_comb begin
    hold_d = hold_q;
    if (!pins[2]) hold_d = ~pins[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      sck_d_q <= pins[2];
      cs_d_q  <= ~pins[3];
      hold_q  <= hold_d;
    end
  end

  assign cs_act   = ~pins[3];
  assign cs_rise  = cs_d_q & pins[3];
  assign sck_rise = pins[2] & ~sck_d_q & ~hold_q & cs_act;
  assign sck_fall = ~pins[2] & sck_d_q & ~hold_q & cs_act;
  assign si_s     = pins[1];
  assign hold_act = hold_q;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic                        clk,
  input  logic                        commit,
  input  logic [ADDR_W-1:0]           page_base,
  input  logic [PAGE_BYTES-1:0][7:0]  wdata,
  input  logic [PAGE_BYTES-1:0]       wmask,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [7:0]                  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = $clog2(PAGE_BYTES);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit && wmask[i])
        mem[{page_base[ADDR_W-1:PG_W], PG_W'(i)}] <= wdata[i];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_mem_top.sv
module spi_mem_top
  import spi_mem_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_si,
  input  logic       spi_hold_n,
  output logic       spi_so,
  output logic       spi_so_oe,
  output logic       prot_req,
  output logic [7:0] prot_addr,
  output logic       prot_status,
  input  logic       prot_grant,
  input  logic [5:0] stat_flags,
  output logic       stat_wr,
  output logic [7:0] stat_wdata,
  output logic       busy
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic cs_act, cs_rise, sck_rise, sck_fall, si_s, hold_act;

  spi_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .si(spi_si),
    .hold_n(spi_hold_n), .cs_act(cs_act), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .hold_act(hold_act)
  );

  phase_t ph_q, ph_d;
  logic [2:0] bit_q, bit_d;
  logic [6:0] rx_q, rx_d;
  logic [7:0] adr_q, adr_d, tx_q, tx_d, sdat_q, sdat_d;
  logic so_q, so_d, wel_q, wel_d, got_q, got_d;
  logic [PAGE_BYTES-1:0][7:0] pbuf_q, pbuf_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic [7:0] rx_byte, rd_addr, rd_data, status;
  logic seq_done, wr_ok, commit_mem;

  assign rx_byte = {rx_q, si_s};
  assign busy    = (cnt_q != '0);
  assign status  = {stat_flags, wel_q, busy};
  assign rd_addr = (ph_q == PH_RADDR) ? rx_byte : adr_q + 8'd1;

  // write sequence complete: whole bytes, at least one data byte
  assign seq_done = cs_rise && got_q && (bit_q == 3'd0) &&
                    (ph_q == PH_WDATA || ph_q == PH_SDONE);
  assign wr_ok       = seq_done && wel_q && !busy;
  assign prot_req    = wr_ok;
  assign prot_status = (ph_q == PH_SDONE);
  assign prot_addr   = prot_status ? 8'd0 : {adr_q[7:PG_W], {PG_W{1'b0}}};
  assign commit_mem  = wr_ok && prot_grant && (ph_q == PH_WDATA);
  assign stat_wr     = wr_ok && prot_grant && (ph_q == PH_SDONE);
  assign stat_wdata  = sdat_q;

  spi_mem_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .commit(commit_mem), .page_base(adr_q), .wdata(pbuf_q),
    .wmask(mask_q), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_comb begin
    ph_d = ph_q; bit_d = bit_q; rx_d = rx_q; adr_d = adr_q; tx_d = tx_q;
    sdat_d = sdat_q; so_d = so_q; wel_d = wel_q; got_d = got_q;
    pbuf_d = pbuf_q; mask_d = mask_q;
    if (!cs_act) begin
      ph_d = PH_CMD; bit_d = 3'd0; got_d = 1'b0;
      if (seq_done) wel_d = 1'b0;
    end else if (sck_rise) begin
      rx_d  = rx_byte[6:0];
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        unique case (ph_q)
          PH_CMD: begin
            if (busy && rx_byte != OP_RDSR) ph_d = PH_SDONE;
            else begin
              case (rx_byte)
                OP_WREN: begin wel_d = 1'b1; ph_d = PH_SDONE; end
                OP_WRDI: begin wel_d = 1'b0; ph_d = PH_SDONE; end
                OP_RDSR: begin tx_d = status; ph_d = PH_STAT; end
                OP_WRSR: ph_d = PH_SBYTE;
                OP_READ: ph_d = PH_RADDR;
                OP_WRIT: ph_d = PH_WADDR;
                default: ph_d = PH_SDONE;
              endcase
            end
          end
          PH_RADDR: begin adr_d = rx_byte; tx_d = rd_data; ph_d = PH_RDATA; end
          PH_RDATA: begin adr_d = adr_q + 8'd1; tx_d = rd_data; end
          PH_WADDR: begin adr_d = rx_byte; mask_d = '0; ph_d = PH_WDATA; end
          PH_WDATA: begin
            pbuf_d[adr_q[PG_W-1:0]] = rx_byte;
            mask_d[adr_q[PG_W-1:0]] = 1'b1;
            adr_d = {adr_q[7:PG_W], adr_q[PG_W-1:0] + PG_W'(1)};
            got_d = 1'b1;
          end
          PH_SBYTE: begin sdat_d = rx_byte; got_d = 1'b1; ph_d = PH_SDONE; end
          PH_STAT:  tx_d = status;
          PH_SDONE: ;
        endcase
      end
    end else if (sck_fall && (ph_q == PH_RDATA || ph_q == PH_STAT)) begin
      so_d = tx_q[7];
      tx_d = {tx_q[6:0], 1'b0};
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (commit_mem || stat_wr) cnt_d = CNT_W'(WRITE_CYCLES);
    else if (cnt_q != '0)      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_CMD; bit_q <= 3'd0; rx_q <= '0; adr_q <= '0; tx_q <= '0;
      sdat_q <= '0; so_q <= 1'b0; wel_q <= 1'b0; got_q <= 1'b0;
      mask_q <= '0; cnt_q <= '0;
    end else begin
      ph_q <= ph_d; bit_q <= bit_d; rx_q <= rx_d; adr_q <= adr_d; tx_q <= tx_d;
      sdat_q <= sdat_d; so_q <= so_d; wel_q <= wel_d; got_q <= got_d;
      mask_q <= mask_d; cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cs_act && sck_rise) pbuf_q <= pbuf_d;
  end

  assign spi_so    = so_q;
  assign spi_so_oe = cs_act && !hold_act && (ph_q == PH_RDATA || ph_q == PH_STAT);
endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic cs_rise,
  input logic hold_act,
  input logic so_oe,
  input logic prot_req,
  input logic prot_grant,
  input logic prot_status,
  input logic commit,
  input logic stat_wr,
  input logic busy
);
  assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !so_oe);
  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !so_oe);
  assert_req_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prot_req |-> cs_rise);
  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prot_req |=> !prot_req);
  assert_commit_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (prot_req && prot_grant && !prot_status));
  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || stat_wr) |=> busy);
  assert_busy_noreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prot_req);
  assert_stat_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> (prot_req && prot_grant && prot_status));
endmodule

bind spi_mem_top spi_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
  .hold_act(hold_act), .so_oe(spi_so_oe), .prot_req(prot_req),
  .prot_grant(prot_grant), .prot_status(prot_status), .commit(commit_mem),
  .stat_wr(stat_wr), .busy(busy)
);

// File: tb/sim_spi_mem_top.sv
module sim_spi_mem_top;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;
  localparam int WCYC   = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, grant = 1'b1;
  logic [5:0] flags = 6'b101010;
  logic so, so_oe, preq, pstat, swr, busy;
  logic [7:0] paddr, swdata;

  int n_chk = 0, n_bad = 0, req_cnt = 0, sw_cnt = 0, run_len = 0;
  logic [7:0] last_paddr = '0, last_sw = '0;
  logic last_pstat = 1'b0, busy_prev = 1'b0, finished = 1'b0;

  spi_mem_top #(.PAGE_BYTES(16), .WRITE_CYCLES(WCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .prot_req(preq),
    .prot_addr(paddr), .prot_status(pstat), .prot_grant(grant),
    .stat_flags(flags), .stat_wr(swr), .stat_wdata(swdata), .busy(busy)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (preq) begin req_cnt++; last_paddr = paddr; last_pstat = pstat; end
    if (swr) begin sw_cnt++; last_sw = swdata; end
    if (busy && !busy_prev) run_len = 1;
    else if (busy) run_len++;
    busy_prev = busy;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    #(n*CLK_NS);
  endtask

  task automatic bits(input logic [7:0] tx, input int hi, input int lo, inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      si = tx[i];
      wait_clk(HALF);
      rx[i] = so;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r = '0;
    bits(tx, 7, 0, r);
    rx = r;
  endtask

  task automatic sel();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic write1(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] d;
    cmd1(8'h06);
    sel(); xfer(8'h02, d); xfer(a, d); xfer(v, d); desel();
  endtask

  task automatic read1(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h03, d); xfer(a, d); xfer(8'h00, v); desel();
  endtask

  task automatic wait_idle();
    wait_clk(WCYC + 20);
  endtask

  // {addr, data, grant, expected readback}
  localparam logic [24:0] VEC [8] = '{
    {8'h00, 8'hA5, 1'b1, 8'hA5}, {8'h01, 8'h3C, 1'b1, 8'h3C},
    {8'h7F, 8'h81, 1'b1, 8'h81}, {8'hFF, 8'h5A, 1'b1, 8'h5A},
    {8'h80, 8'h00, 1'b1, 8'h00}, {8'h01, 8'h77, 1'b0, 8'h3C},
    {8'h2B, 8'hFE, 1'b1, 8'hFE}, {8'h7F, 8'h11, 1'b0, 8'h81}
  };

  initial begin
    logic [7:0] d, r, s;
    int rq;
    #2;
    wait_clk(5);
    // R1 reset state
    chk("R1 so_oe", so_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 prot_req", preq, 0);
    chk("R1 stat_wr", swr, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // table: write one byte, then read it back (R3, R11)
    for (int k = 0; k < 8; k++) begin
      grant = VEC[k][8];
      rq = req_cnt;
      write1(VEC[k][24:17], VEC[k][16:9]);
      chk("R11 one request", req_cnt - rq, 1);
      chk("R11 page base", last_paddr, {VEC[k][24:21], 4'h0});
      chk("R4 busy after commit", busy, VEC[k][8]);
      if (VEC[k][8]) wait_idle();
      grant = 1'b1;
      read1(VEC[k][24:17], r);
      chk("R3 readback", r, VEC[k][7:0]);
    end

    // R2 wrap from 0xFF to 0x00, and SO enabled while reading
    sel(); xfer(8'h03, d); xfer(8'hFF, d);
    wait_clk(2);
    chk("R2 so_oe while reading", so_oe, 1);
    xfer(8'h00, r); chk("R2 byte at FF", r, 8'h5A);
    xfer(8'h00, r); chk("R2 wrapped to 00", r, 8'hA5);
    xfer(8'h00, r); chk("R2 increment to 01", r, 8'h3C);
    desel();

    // R3 page wrap: 18 bytes from 0x1E within page 0x10..0x1F
    cmd1(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h1E, d);
    for (int k = 0; k < 18; k++) xfer(8'h40 + 8'(k), d);
    desel();
    wait_idle();
    sel(); xfer(8'h03, d); xfer(8'h10, d);
    for (int k = 0; k < 16; k++) begin
      xfer(8'h00, r);
      chk("R3 page wrap", r, (k < 14) ? 8'h42 + 8'(k) : 8'h50 + 8'(k - 14));
    end
    desel();

    // R4/R5: busy period, status during busy, commands ignored
    write1(8'h30, 8'h99);
    chk("R4 busy high", busy, 1);
    rdsr(s); chk("R4 status busy, WEL cleared R6", s, 8'hA9);
    cmd1(8'h06);
    rdsr(s); chk("R5 WREN ignored while busy", s, 8'hA9);
    sel(); xfer(8'h03, d); xfer(8'h30, d);
    wait_clk(2);
    chk("R5 read ignored while busy", so_oe, 0);
    desel();
    wait_idle();
    chk("R4 busy length", run_len, WCYC);
    rdsr(s); chk("R4 status idle", s, 8'hA8);
    read1(8'h30, r); chk("R4 data committed", r, 8'h99);

    // R6 write enable latch
    cmd1(8'h06);
    rdsr(s); chk("R6 WEL set", s, 8'hAA);
    cmd1(8'h04);
    rdsr(s); chk("R6 WEL cleared", s, 8'hA8);
    rq = req_cnt;
    sel(); xfer(8'h02, d); xfer(8'h30, d); xfer(8'h12, d); desel();
    chk("R6 no request without WEL", req_cnt - rq, 0);

    // R7 aborted mid-byte and no-data sequences
    cmd1(8'h06);
    rq = req_cnt;
    r = '0;
    sel(); xfer(8'h02, d); xfer(8'h30, d); bits(8'hF0, 7, 4, r); desel();
    chk("R7 mid-byte abort", req_cnt - rq, 0);
    sel(); xfer(8'h02, d); xfer(8'h30, d); desel();
    chk("R7 no data byte", req_cnt - rq, 0);
    chk("R7 not busy", busy, 0);
    read1(8'h30, r); chk("R7 array unchanged", r, 8'h99);
    cmd1(8'h04);

    // R8 hold in the middle of a data byte at address 0x00 (0xA5)
    r = '0;
    sel(); xfer(8'h03, d); xfer(8'h00, d);
    bits(8'h00, 7, 5, r);
    hold_n = 1'b0; wait_clk(HALF);
    chk("R8 SO disabled on hold", so_oe, 0);
    for (int k = 0; k < 2; k++) begin
      si = ~si; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    hold_n = 1'b1; wait_clk(HALF);
    chk("R8 SO back after release", so_oe, 1);
    bits(8'h00, 4, 0, r);
    chk("R8 byte intact across hold", r, 8'hA5);
    xfer(8'h00, r); chk("R8 next address", r, 8'h3C);
    desel();

    // R9 CS high disables SO and drops a partial command
    chk("R9 SO disabled when deselected", so_oe, 0);
    r = '0;
    sel(); bits(8'h03, 7, 4, r); desel();
    rdsr(s); chk("R9 fresh command after discard", s, 8'hA8);

    // R10 status write
    cmd1(8'h06);
    rq = req_cnt;
    sel(); xfer(8'h01, d); xfer(8'h8C, d); desel();
    chk("R10 request raised", req_cnt - rq, 1);
    chk("R10 request targets status", last_pstat, 1);
    chk("R10 one strobe", sw_cnt, 1);
    chk("R10 status data", last_sw, 8'h8C);
    chk("R10 busy started", busy, 1);
    wait_idle();

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule